// File: doc/BRIEF.md
# Debug Memory Write Engine

This engine lets an external debug tool write into target memory without the processor's help. The tool reaches it through a small indexed register write port. It loads a target address, then a control word that selects the access size, the bus priority and a transfer count. Each later write of a data word starts exactly one single-beat write on the system bus. The bus master side raises a request and holds it until the bus reports the transfer done.

A count of zero or one gives a single write. A larger count gives a non-burst block. In a block, every successful beat moves the address on by the access size and lowers the remaining count. The tool supplies each further word with a fresh data-register write. Only three pieces of status reach the tool: a one-cycle ready pulse per good transfer, a data-valid flag that marks an access in progress, and an error flag. A bus error ends the access at once. The error flag stays set until the next control write.

Top module: `dbg_wr_engine`

## Requirements
- R1: After synchronous reset, bus_req, rdy, stat_dv and stat_err are 0, bus_addr is 0 and bus_be is 0.
- R2: Register index 0x9 loads the target address, 0x7 loads the control word and 0xA loads the data word. Writes to any other index change nothing.
- R3: The control word has these fields: start at bit 31, map at bits 30:28, priority at bits 27:26, write at bit 25, size at bits 24:22 and count at bits 15:0. A data write starts a transfer only if the last control word had start=1, write=1 and map=000, and its size was 000, 001 or 010. With any other control word, data writes start nothing.
- R4: A data write that finds the engine armed and idle sets stat_dv and raises bus_req in the next cycle. bus_req then stays high until bus_done is seen in a cycle where bus_grant is high, or after bus_grant was seen earlier in the same transfer.
- R5: While bus_req is high, bus_addr equals the address register and bus_prio equals the priority field. bus_wdata carries the data word with its low byte (size 000) or its low halfword (size 001) copied into every lane; with size 010 it carries the full word.
- R6: While bus_req is high, bus_be is 1<<addr[1:0] for size 000, 4'b0011<<{addr[1],1'b0} for size 001 and 4'b1111 for size 010. While bus_req is low, bus_be is 0.
- R7: A transfer that completes without bus_err raises rdy for exactly one cycle, the cycle after completion.
- R8: A count of 0 or 1 performs one transfer. stat_dv falls together with the rdy pulse of that transfer.
- R9: With a count N>1, each good transfer adds 1, 2 or 4 (for size 000, 001 or 010) to the address. stat_dv stays 1 between transfers and falls with the rdy pulse of the N-th transfer.
- R10: Once the count is used up, data writes start no transfer until a new control word is written.
- R11: A transfer that completes with bus_err sets stat_err, clears stat_dv and gives no rdy pulse. It leaves the address unchanged and cancels the rest of the block, so later data writes start nothing.
- R12: A control write clears stat_err.
- R13: Register writes made while bus_req is high are ignored. They change neither the transfer in flight nor the address that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| bus_req | output | 1 | Bus request, held until the transfer completes |
| bus_addr | output | ADDR_W | Target byte address |
| bus_wdata | output | 32 | Write data, lane-replicated |
| bus_be | output | 4 | Byte enables |
| bus_prio | output | 2 | Requested bus priority |
| bus_grant | input | 1 | Bus granted to this master |
| bus_done | input | 1 | Transfer finished this cycle |
| bus_err | input | 1 | Transfer finished with an error |
| rdy | output | 1 | One-cycle ready pulse after a good transfer |
| stat_dv | output | 1 | Access in progress |
| stat_err | output | 1 | Last transfer failed |

## Verification
The bench builds the engine with its default 32-bit address. At that width, start addresses near the top of every lane offset, plus halfword and word alignment, are all reachable. A bench bus responder varies the delay from request to grant and from grant to done, so the engine sees both a grant that arrives with done and a grant that arrives before done. Every case is played against a behavioural model that is compared on each clock: single and block writes of every size, counts of zero and one, an error in the middle of a block, refused control words, and writes to an unknown index or during a transfer.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;

    localparam int IDX_W  = 4;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int CNT_W  = 16;

    localparam logic [IDX_W-1:0] IDX_CTRL = 4'h7;
    localparam logic [IDX_W-1:0] IDX_ADDR = 4'h9;
    localparam logic [IDX_W-1:0] IDX_DATA = 4'hA;

    typedef enum logic [2:0] {
        SZ_BYTE = 3'b000,
        SZ_HALF = 3'b001,
        SZ_WORD = 3'b010
    } size_e;

    typedef struct packed {
        logic             go;
        logic [2:0]       map;
        logic [1:0]       prio;
        logic             wr;
        logic [2:0]       size;
        logic [5:0]       rsvd;
        logic [CNT_W-1:0] cnt;
    } ctrl_word_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_HELD = 2'd2
    } seq_state_e;

    function automatic logic size_legal(input logic [2:0] s);
        return (s == SZ_BYTE) || (s == SZ_HALF) || (s == SZ_WORD);
    endfunction

    function automatic logic [2:0] size_step(input logic [2:0] s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic lane_hit(input logic [2:0] s, input logic [1:0] off,
                                      input int lane);
        logic [1:0] l;
        l = 2'(lane);
        case (s)
            SZ_BYTE: return l == off;
            SZ_HALF: return l[1] == off[1];
            SZ_WORD: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dbgw_regs.sv
module dbgw_regs
    import dbgw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              busy,
    input  logic              xfer_ok,
    input  logic              xfer_fail,
    output logic [ADDR_W-1:0] addr,
    output logic [2:0]        size,
    output logic [1:0]        prio,
    output logic [WORD_W-1:0] data,
    output logic              ctrl_wr,
    output logic              launch,
    output logic              last
);

    ctrl_word_t       cw;
    logic             addr_wr, data_wr;
    logic             armed_q;
    logic [CNT_W-1:0] rem_q;

    assign cw      = ctrl_word_t'(reg_wdata);
    assign addr_wr = reg_we && !busy && (reg_idx == IDX_ADDR);
    assign ctrl_wr = reg_we && !busy && (reg_idx == IDX_CTRL);
    assign data_wr = reg_we && !busy && (reg_idx == IDX_DATA);
    assign launch  = data_wr && armed_q;
    assign last    = (rem_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr    <= '0;
            size    <= SZ_BYTE;
            prio    <= '0;
            data    <= '0;
            armed_q <= 1'b0;
            rem_q   <= '0;
        end else begin
            if (addr_wr) addr <= reg_wdata[ADDR_W-1:0];
            if (ctrl_wr) begin
                size    <= cw.size;
                prio    <= cw.prio;
                armed_q <= cw.go && cw.wr && (cw.map == 3'b000) && size_legal(cw.size);
                rem_q   <= (cw.cnt == '0) ? CNT_W'(1) : cw.cnt;
            end
            if (data_wr) data <= reg_wdata;
            if (xfer_ok) begin
                addr  <= addr + ADDR_W'(size_step(size));
                rem_q <= rem_q - CNT_W'(1);
                if (last) armed_q <= 1'b0;
            end
            if (xfer_fail) begin
                armed_q <= 1'b0;
                rem_q   <= '0;
            end
        end
    end

    // R11
    fail_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_fail |=> $stable(addr));

    // R10
    exhaust_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_ok && last) |=> !launch);

endmodule

// File: rtl/dbgw_seq.sv
module dbgw_seq
    import dbgw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic ctrl_wr,
    input  logic last,
    input  logic bus_grant,
    input  logic bus_done,
    input  logic bus_err,
    output logic busy,
    output logic xfer_ok,
    output logic xfer_fail,
    output logic rdy,
    output logic dv,
    output logic err
);

    seq_state_e state_q, state_d;
    logic       finish;

    assign busy      = (state_q != ST_IDLE);
    assign finish    = bus_done && ((state_q == ST_REQ && bus_grant) || state_q == ST_HELD);
    assign xfer_ok   = finish && !bus_err;
    assign xfer_fail = finish && bus_err;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (launch) state_d = ST_REQ;
            ST_REQ: begin
                if (finish)         state_d = ST_IDLE;
                else if (bus_grant) state_d = ST_HELD;
            end
            ST_HELD: if (finish) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rdy     <= 1'b0;
            dv      <= 1'b0;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            rdy     <= xfer_ok;
            if (ctrl_wr) begin
                dv  <= 1'b0;
                err <= 1'b0;
            end
            if (launch) dv <= 1'b1;
            if (xfer_ok && last) dv <= 1'b0;
            if (xfer_fail) begin
                dv  <= 1'b0;
                err <= 1'b1;
            end
        end
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !bus_done) |=> busy);

    // R4
    dv_during_req_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> dv);

    // R7
    rdy_source_chk: assert property (@(posedge clk) disable iff (rst)
        rdy |-> $past(busy && bus_done && !bus_err));

    // R7
    rdy_single_chk: assert property (@(posedge clk) disable iff (rst)
        rdy |=> !rdy);

    // R11
    err_no_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_fail |=> (!rdy && err && !dv));

endmodule

// File: rtl/dbgw_lane.sv
module dbgw_lane
    import dbgw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [2:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] data,
    output logic [LANES-1:0]  be,
    output logic [WORD_W-1:0] lane_data
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be[i] = active && lane_hit(size, addr[1:0], i);
        always_comb begin
            case (size)
                SZ_BYTE: lane_data[8*i +: 8] = data[7:0];
                SZ_HALF: lane_data[8*i +: 8] = data[8*(i%2) +: 8];
                default: lane_data[8*i +: 8] = data[8*i +: 8];
            endcase
        end
    end

    // R6
    byte_lane_one_chk: assert property (@(posedge clk) disable iff (rst)
        (active && size == SZ_BYTE) |-> ($countones(be) == 1));

    // R6
    idle_no_lane_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> (be == '0));

endmodule

// File: rtl/dbg_wr_engine.sv
module dbg_wr_engine
    import dbgw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [3:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    output logic [3:0]        bus_be,
    output logic [1:0]        bus_prio,
    input  logic              bus_grant,
    input  logic              bus_done,
    input  logic              bus_err,
    output logic              rdy,
    output logic              stat_dv,
    output logic              stat_err
);

    logic              busy, xfer_ok, xfer_fail, ctrl_wr, launch, last;
    logic [ADDR_W-1:0] addr;
    logic [2:0]        size;
    logic [1:0]        prio;
    logic [WORD_W-1:0] data;

    dbgw_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .busy(busy), .xfer_ok(xfer_ok),
        .xfer_fail(xfer_fail), .addr(addr), .size(size), .prio(prio),
        .data(data), .ctrl_wr(ctrl_wr), .launch(launch), .last(last)
    );

    dbgw_seq u_seq (
        .clk(clk), .rst(rst), .launch(launch), .ctrl_wr(ctrl_wr), .last(last),
        .bus_grant(bus_grant), .bus_done(bus_done), .bus_err(bus_err),
        .busy(busy), .xfer_ok(xfer_ok), .xfer_fail(xfer_fail),
        .rdy(rdy), .dv(stat_dv), .err(stat_err)
    );

    dbgw_lane #(.ADDR_W(ADDR_W)) u_lane (
        .clk(clk), .rst(rst), .active(busy), .size(size), .addr(addr),
        .data(data), .be(bus_be), .lane_data(bus_wdata)
    );

    assign bus_req  = busy;
    assign bus_addr = addr;
    assign bus_prio = prio;

    // R13
    busy_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_done) |=> $stable(bus_addr));

endmodule

// File: tb/sim_dbg_wr_engine.sv
`timescale 1ns/1ps
module sim_dbg_wr_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic        bus_req, rdy, stat_dv, stat_err;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic [1:0]  bus_prio;
    logic        bus_grant = 1'b0, bus_done = 1'b0, bus_error = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int g_lat = 0, d_lat = 0, rctr = 0;
    bit err_inj = 1'b0;

    always #4 clk = ~clk;

    dbg_wr_engine u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_prio(bus_prio),
        .bus_grant(bus_grant), .bus_done(bus_done), .bus_err(bus_error),
        .rdy(rdy), .stat_dv(stat_dv), .stat_err(stat_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // bus responder: grant after g_lat cycles of request, done after d_lat
    always @(posedge clk) begin
        #3;
        if (bus_req) begin
            bus_grant = (rctr >= g_lat);
            bus_done  = (rctr >= d_lat);
            bus_error = err_inj && bus_done;
            rctr++;
        end else begin
            rctr = 0;
            bus_grant = 1'b0;
            bus_done  = 1'b0;
            bus_error = 1'b0;
        end
    end

    // behavioural reference model
    logic [31:0] m_addr, m_data;
    int  m_size, m_prio, m_rem;
    bit  m_armed, m_busy, m_gnt, m_dv, m_err, m_rdy;

    always @(posedge clk) begin
        if (rst) begin
            m_addr = 0; m_data = 0; m_size = 0; m_prio = 0; m_rem = 0;
            m_armed = 0; m_busy = 0; m_gnt = 0; m_dv = 0; m_err = 0; m_rdy = 0;
        end else begin
            m_rdy = 0;
            if (m_busy) begin
                if (bus_done && (bus_grant || m_gnt)) begin
                    m_busy = 0; m_gnt = 0;
                    if (bus_error) begin
                        m_err = 1; m_dv = 0; m_armed = 0; m_rem = 0;
                    end else begin
                        m_rdy = 1;
                        m_addr = m_addr + (32'd1 << m_size);
                        m_rem = m_rem - 1;
                        if (m_rem == 0) begin m_dv = 0; m_armed = 0; end
                    end
                end else if (bus_grant) m_gnt = 1;
            end else if (reg_we) begin
                if (reg_idx == 4'h9) m_addr = reg_wdata;
                else if (reg_idx == 4'h7) begin
                    m_size = int'(reg_wdata[24:22]);
                    m_prio = int'(reg_wdata[27:26]);
                    m_armed = reg_wdata[31] && reg_wdata[25] && reg_wdata[30:28] == 3'b000 && m_size <= 2;
                    m_rem = (reg_wdata[15:0] == 0) ? 1 : int'(reg_wdata[15:0]);
                    m_err = 0; m_dv = 0;
                end else if (reg_idx == 4'hA) begin
                    m_data = reg_wdata;
                    if (m_armed) begin m_busy = 1; m_dv = 1; end
                end
            end
        end
    end

    function automatic logic [3:0] exp_be(input int s, input logic [31:0] a);
        if (s == 0) return 4'b0001 << a[1:0];
        if (s == 1) return 4'b0011 << {a[1], 1'b0};
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_wd(input int s, input logic [31:0] d);
        if (s == 0) return {4{d[7:0]}};
        if (s == 1) return {2{d[15:0]}};
        return d;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            check("R4 bus_req", 32'(bus_req), 32'(m_busy));
            if (m_busy) begin
                check("R5 bus_addr", bus_addr, m_addr);
                check("R5 bus_wdata", bus_wdata, exp_wd(m_size, m_data));
                check("R5 bus_prio", 32'(bus_prio), 32'(m_prio));
                check("R6 bus_be", 32'(bus_be), 32'(exp_be(m_size, m_addr)));
            end else begin
                check("R6 idle bus_be", 32'(bus_be), 32'd0);
            end
            check("R7 rdy", 32'(rdy), 32'(m_rdy));
            check("R9 stat_dv", 32'(stat_dv), 32'(m_dv));
            check("R11 stat_err", 32'(stat_err), 32'(m_err));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] val);
        step();
        reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
        step();
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (bus_req && n < 1000) begin
            step();
            n++;
        end
    endtask

    function automatic logic [31:0] mk(input bit go, input logic [2:0] map, input logic [1:0] pr,
                                       input bit w, input logic [2:0] sz, input logic [15:0] cnt);
        return {go, map, pr, w, sz, 6'b0, cnt};
    endfunction

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        check("R1 bus_req", 32'(bus_req), 0);
        check("R1 rdy", 32'(rdy), 0);
        check("R1 stat_dv", 32'(stat_dv), 0);
        check("R1 stat_err", 32'(stat_err), 0);
        check("R1 bus_addr", bus_addr, 0);
        check("R1 bus_be", 32'(bus_be), 0);

        // single word write
        g_lat = 1; d_lat = 2;
        wr(4'h9, 32'h1000_0000);
        wr(4'h7, mk(1, 3'b000, 2'd2, 1, 3'b010, 16'd1));
        wr(4'hA, 32'hDEAD_BEEF);
        check("R4 req after data", 32'(bus_req), 1);
        check("R4 dv set", 32'(stat_dv), 1);
        wait_idle();
        check("R7 rdy pulse", 32'(rdy), 1);
        check("R8 dv cleared single", 32'(stat_dv), 0);
        check("R9 address advanced", bus_addr, 32'h1000_0004);
        step();
        check("R7 rdy one cycle", 32'(rdy), 0);

        // count zero, halfword
        g_lat = 0; d_lat = 0;
        wr(4'h9, 32'h0000_2002);
        wr(4'h7, mk(1, 3'b000, 2'd1, 1, 3'b001, 16'd0));
        wr(4'hA, 32'h1234_ABCD);
        check("R6 half be", 32'(bus_be), 32'h0000_000C);
        wait_idle();
        check("R8 count zero single", 32'(stat_dv), 0);
        wr(4'hA, 32'h5555_5555);
        check("R10 no restart", 32'(bus_req), 0);

        // byte block of 5
        wr(4'h9, 32'hFFFF_FFFD);
        wr(4'h7, mk(1, 3'b000, 2'd3, 1, 3'b000, 16'd5));
        for (int i = 0; i < 5; i++) begin
            d_lat = i; g_lat = 0;
            wr(4'hA, 32'h0000_0040 + 32'(i));
            wait_idle();
            check("R9 dv across block", 32'(stat_dv), (i == 4) ? 0 : 1);
            check("R9 byte address", bus_addr, 32'hFFFF_FFFD + 32'(i + 1));
        end
        wr(4'hA, 32'h0000_0099);
        check("R10 block exhausted", 32'(bus_req), 0);

        // halfword block of 3, grant before done
        g_lat = 0; d_lat = 3;
        wr(4'h9, 32'h0000_4000);
        wr(4'h7, mk(1, 3'b000, 2'd0, 1, 3'b001, 16'd3));
        for (int i = 0; i < 3; i++) begin
            wr(4'hA, 32'hA5A5_0000 + 32'(i));
            wait_idle();
            check("R9 half address", bus_addr, 32'h0000_4000 + 32'(2 * (i + 1)));
        end
        check("R9 dv end", 32'(stat_dv), 0);

        // error in mid-block
        g_lat = 1; d_lat = 1;
        wr(4'h9, 32'h0000_5000);
        wr(4'h7, mk(1, 3'b000, 2'd2, 1, 3'b010, 16'd4));
        wr(4'hA, 32'h0101_0101);
        wait_idle();
        err_inj = 1'b1;
        wr(4'hA, 32'h0202_0202);
        wait_idle();
        err_inj = 1'b0;
        check("R11 err set", 32'(stat_err), 1);
        check("R11 dv cleared", 32'(stat_dv), 0);
        check("R11 no rdy", 32'(rdy), 0);
        check("R11 addr held", bus_addr, 32'h0000_5004);
        wr(4'hA, 32'h0303_0303);
        check("R11 block aborted", 32'(bus_req), 0);
        wr(4'h7, mk(0, 3'b000, 2'd0, 1, 3'b010, 16'd1));
        check("R12 err cleared", 32'(stat_err), 0);

        // refused control words
        wr(4'h7, mk(1, 3'b000, 2'd0, 0, 3'b010, 16'd1));
        wr(4'hA, 32'h1);
        check("R3 read rejected", 32'(bus_req), 0);
        wr(4'h7, mk(1, 3'b001, 2'd0, 1, 3'b010, 16'd1));
        wr(4'hA, 32'h2);
        check("R3 map rejected", 32'(bus_req), 0);
        wr(4'h7, mk(1, 3'b000, 2'd0, 1, 3'b011, 16'd1));
        wr(4'hA, 32'h3);
        check("R3 size rejected", 32'(bus_req), 0);

        // unknown index ignored
        wr(4'h9, 32'h0000_6000);
        wr(4'h5, 32'h0BAD_0BAD);
        wr(4'h7, mk(1, 3'b000, 2'd1, 1, 3'b010, 16'd1));
        wr(4'h5, 32'h0BAD_0BAD);
        wr(4'hA, 32'h6666_6666);
        check("R2 addr kept", bus_addr, 32'h0000_6000);
        check("R2 data kept", bus_wdata, 32'h6666_6666);
        wait_idle();

        // writes during transfer ignored
        g_lat = 2; d_lat = 9;
        wr(4'h9, 32'h0000_7000);
        wr(4'h7, mk(1, 3'b000, 2'd0, 1, 3'b010, 16'd1));
        wr(4'hA, 32'h1111_1111);
        wr(4'h9, 32'h0000_9999);
        wr(4'hA, 32'h2222_2222);
        check("R13 busy", 32'(bus_req), 1);
        check("R13 addr unchanged", bus_addr, 32'h0000_7000);
        check("R13 data unchanged", bus_wdata, 32'h1111_1111);
        wait_idle();
        check("R13 addr after", bus_addr, 32'h0000_7004);

        step();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule